// File: doc/BRIEF.md
# SDRAM Presence-Detect Decoder

This block listens to the bytes of an SDRAM presence-detect image as they arrive one at a time, each tagged with its index from 0 to 63. It keeps the few bytes that describe the memory's shape and timing, and it keeps a running checksum of the image. From those bytes it works out the values a memory controller needs to run the module. These are the device geometry (rows, columns, banks, chip selects), the CAS latency, the refresh timer count, and the derived fields: total size, address mask, row start, column multiplex count, bank-select position, A10 position and load-to-precharge count.

The geometry and field outputs are combinational functions of the bytes kept so far. They are meant to be read after the end-of-image pulse. That pulse comes one cycle after byte 63 is accepted. In the same cycle the checksum-error flag and two warning flags are updated. The interleave scheme (page or bank) and the CAS selection policy (optimistic or pessimistic) are static parameters.

Top module: `spd_decoder`

## Requirements
- R1: Rows are taken from the low nibble of byte 3 and clamped to at most 14. Columns are taken from the low nibble of byte 4 and clamped to at most 11. Chip selects are the low nibble of byte 5.
- R2: Byte 17 gives the bank count. A value of 2, 4 or 8 gives `bank_log2` 1, 2 or 3. Any other value gives 0.
- R3: `refresh_cnt` is looked up from bits 6:0 of byte 12. Code 0 gives 14, 1 gives 2, 2 gives 6, 3 gives 29, 4 gives 60 and 5 gives 120. Any other code gives 14.
- R4: CAS latency comes from bits 2:0 of byte 18, where bit k stands for latency k+1. With PESSIMISTIC=0 the lowest set bit wins; with PESSIMISTIC=1 the highest set bit wins. If none of the three bits is set, the latency is 3 and `cas_warn` is set at the end of the image. A latency below 2 is raised to 2. `ld_to_pre` equals the latency minus 1.
- R5: The data width is byte 7 × 256 + byte 6. At the end of the image, `width_warn` is set when the width is neither 64 nor 72, and cleared otherwise.
- R6: At the end of the image, `cksum_err` is set when the 8-bit sum of bytes 0 to 62 differs from byte 63. Byte 0 restarts the sum.
- R7: `mem_size` = 2^(rows+cols+bank_log2+3) and `addr_mask` = ~(mem_size−1), both 32 bits wide.
- R8: With PAGE_ILV=1, `row_start` = 32−(rows+bank_log2+cols+3), `col_mux` = cols−6 and `a10_pos` = `col_mux`.
- R9: With PAGE_ILV=0, `row_start` = (26−(rows+cols+3))×2, `col_mux` = cols−8 and `a10_pos` = `col_mux`+2.
- R10: `bank_sel_pos` = 14−max(rows, cols). This value and every field in R8 and R9 wrap modulo 256.
- R11: `done` is high for exactly the one cycle after the cycle in which index 63 is accepted. The three flags change only in that cycle and hold their values otherwise.
- R12: A byte whose index is 64 or above changes no output and no kept byte.
- R13: After reset, `done` and all flags are 0 and every kept byte reads as 0. In that state `cas_lat` is 3 and `refresh_cnt` is 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Byte strobe |
| in_idx | input | 8 | Byte index |
| in_data | input | 8 | Byte value |
| done | output | 1 | End-of-image pulse |
| cksum_err | output | 1 | Checksum mismatch |
| width_warn | output | 1 | Unsupported data width |
| cas_warn | output | 1 | No CAS latency bit set |
| chip_sel | output | 4 | Chip-select count |
| rows | output | 4 | Clamped row address bits |
| cols | output | 4 | Clamped column address bits |
| bank_log2 | output | 2 | log2 of the bank count |
| cas_lat | output | 2 | Selected CAS latency |
| ld_to_pre | output | 2 | Load-to-precharge count |
| refresh_cnt | output | 8 | Refresh timer value |
| mem_size | output | 32 | Bytes per chip select |
| addr_mask | output | 32 | Address mask |
| row_start | output | 8 | Row start field |
| col_mux | output | 8 | Column multiplex count |
| bank_sel_pos | output | 8 | Bank-select position |
| a10_pos | output | 8 | A10 field |

## Verification
Every output except the flags and `done` is a pure function of the kept bytes. A kept byte stored in the wrong slot, or one overwritten by an out-of-range index, therefore shows on the field outputs in the very next cycle, so the outputs are compared against a model on every clock. A checksum accumulator that goes wrong stays hidden until the cycle after byte 63, when `cksum_err` takes the wrong value. A wrong end-event decode shows as `done` firing in the wrong cycle or the flags moving outside it. Two instances run on the same stream, one per parameter variant, so that both CAS policies and both interleave formulas are observed.

// File: rtl/spd_pkg.sv
package spd_pkg;

  localparam int SPD_LAST = 63;
  localparam int NKEEP    = 8;

  // slot order of the kept bytes
  localparam int K_ROWS  = 0;
  localparam int K_COLS  = 1;
  localparam int K_CS    = 2;
  localparam int K_WLO   = 3;
  localparam int K_WHI   = 4;
  localparam int K_REF   = 5;
  localparam int K_BANK  = 6;
  localparam int K_CAS   = 7;

  localparam logic [5:0] KEEP_IDX [NKEEP] = '{6'd3, 6'd4, 6'd5, 6'd6, 6'd7, 6'd12, 6'd17, 6'd18};

  typedef struct packed {
    logic [3:0] rows;
    logic [3:0] cols;
    logic [1:0] bank_lg;
    logic [3:0] chip_sel;
    logic [1:0] cas;
    logic       cas_dflt;
    logic [7:0] refresh;
    logic       width_bad;
  } geom_t;

  function automatic logic [7:0] refresh_lookup(input logic [6:0] code);
    case (code)
      7'd1:    return 8'd2;
      7'd2:    return 8'd6;
      7'd3:    return 8'd29;
      7'd4:    return 8'd60;
      7'd5:    return 8'd120;
      default: return 8'd14;
    endcase
  endfunction

  function automatic logic [1:0] bank_log2_of(input logic [7:0] n);
    case (n)
      8'd2:    return 2'd1;
      8'd4:    return 2'd2;
      8'd8:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [3:0] clamp_nib(input logic [3:0] v, input logic [3:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  // returns {no_bit_set, latency}
  function automatic logic [2:0] cas_pick(input logic [2:0] bits, input logic pess);
    logic [1:0] lat;
    logic       none;
    none = (bits == 3'b000);
    if (none)          lat = 2'd3;
    else if (pess)     lat = bits[2] ? 2'd3 : (bits[1] ? 2'd2 : 2'd1);
    else               lat = bits[0] ? 2'd1 : (bits[1] ? 2'd2 : 2'd3);
    if (lat < 2'd2) lat = 2'd2;
    return {none, lat};
  endfunction

endpackage

// File: rtl/spd_capture.sv
module spd_capture #(
  parameter int IDX_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_vld,
  input  logic [IDX_W-1:0]                    in_idx,
  input  logic [7:0]                          in_data,
  output logic [spd_pkg::NKEEP-1:0][7:0]      kept,
  output logic                                end_evt,
  output logic                                sum_bad
);
  import spd_pkg::*;

  logic       in_range;
  logic       accept;
  logic [7:0] sum_q;

  assign in_range = (in_idx <= IDX_W'(SPD_LAST));
  assign accept   = in_vld && in_range;
  assign end_evt  = accept && (in_idx == IDX_W'(SPD_LAST));
  assign sum_bad  = end_evt && (sum_q != in_data);

  for (genvar g = 0; g < NKEEP; g++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q <= 8'd0;
      else if (accept && (in_idx == IDX_W'(KEEP_IDX[g])))
        slot_q <= in_data;
    end
    assign kept[g] = slot_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sum_q <= 8'd0;
    else if (accept && (in_idx == '0))
      sum_q <= in_data;
    else if (accept && !end_evt)
      sum_q <= sum_q + in_data;
  end

  // out-of-range indices leave all stored state alone
  assert_ignore_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_range) |=> ($stable(sum_q) && $stable(kept)));

endmodule

// File: rtl/spd_geom.sv
module spd_geom #(
  parameter bit PESSIMISTIC = 1'b0
) (
  input  logic [spd_pkg::NKEEP-1:0][7:0] kept,
  output spd_pkg::geom_t                 geom
);
  import spd_pkg::*;

  logic [15:0] width;
  logic [2:0]  cas_sel;

  assign width   = {kept[K_WHI], kept[K_WLO]};
  assign cas_sel = cas_pick(kept[K_CAS][2:0], PESSIMISTIC);

  always_comb begin
    geom.rows      = clamp_nib(kept[K_ROWS][3:0], 4'd14);
    geom.cols      = clamp_nib(kept[K_COLS][3:0], 4'd11);
    geom.chip_sel  = kept[K_CS][3:0];
    geom.bank_lg   = bank_log2_of(kept[K_BANK]);
    geom.refresh   = refresh_lookup(kept[K_REF][6:0]);
    geom.cas       = cas_sel[1:0];
    geom.cas_dflt  = cas_sel[2];
    geom.width_bad = (width != 16'd64) && (width != 16'd72);
  end

endmodule

// File: rtl/spd_fields.sv
module spd_fields #(
  parameter bit PAGE_ILV = 1'b1,
  parameter int FW       = 8,
  parameter int AW       = 32
) (
  input  spd_pkg::geom_t  geom,
  output logic [AW-1:0]   mem_size,
  output logic [AW-1:0]   addr_mask,
  output logic [FW-1:0]   row_start,
  output logic [FW-1:0]   col_mux,
  output logic [FW-1:0]   bank_sel_pos,
  output logic [FW-1:0]   a10_pos
);
  logic [5:0]    expo;
  logic [3:0]    widest;

  assign expo      = 6'(geom.rows) + 6'(geom.cols) + 6'(geom.bank_lg) + 6'd3;
  assign mem_size  = AW'(1) << expo;
  assign addr_mask = ~(mem_size - AW'(1));
  assign widest    = (geom.rows > geom.cols) ? geom.rows : geom.cols;
  assign bank_sel_pos = FW'(14) - FW'(widest);

  if (PAGE_ILV) begin : g_page
    assign row_start = FW'(32) - FW'(expo);
    assign col_mux   = FW'(geom.cols) - FW'(6);
    assign a10_pos   = col_mux;
  end else begin : g_bank
    logic [FW-1:0] half;
    assign half      = FW'(26) - FW'(geom.rows) - FW'(geom.cols) - FW'(3);
    assign row_start = {half[FW-2:0], 1'b0};
    assign col_mux   = FW'(geom.cols) - FW'(8);
    assign a10_pos   = col_mux + FW'(2);
  end

endmodule

// File: rtl/spd_decoder.sv
module spd_decoder #(
  parameter bit PAGE_ILV    = 1'b1,
  parameter bit PESSIMISTIC = 1'b0,
  parameter int IDX_W       = 8,
  parameter int FW          = 8,
  parameter int AW          = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [IDX_W-1:0] in_idx,
  input  logic [7:0]       in_data,
  output logic             done,
  output logic             cksum_err,
  output logic             width_warn,
  output logic             cas_warn,
  output logic [3:0]       chip_sel,
  output logic [3:0]       rows,
  output logic [3:0]       cols,
  output logic [1:0]       bank_log2,
  output logic [1:0]       cas_lat,
  output logic [1:0]       ld_to_pre,
  output logic [7:0]       refresh_cnt,
  output logic [AW-1:0]    mem_size,
  output logic [AW-1:0]    addr_mask,
  output logic [FW-1:0]    row_start,
  output logic [FW-1:0]    col_mux,
  output logic [FW-1:0]    bank_sel_pos,
  output logic [FW-1:0]    a10_pos
);
  import spd_pkg::*;

  logic [NKEEP-1:0][7:0] kept;
  logic                  end_evt;
  logic                  sum_bad;
  geom_t                 geom;

  spd_capture #(.IDX_W(IDX_W)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_idx  (in_idx),
    .in_data (in_data),
    .kept    (kept),
    .end_evt (end_evt),
    .sum_bad (sum_bad)
  );

  spd_geom #(.PESSIMISTIC(PESSIMISTIC)) u_geom (
    .kept (kept),
    .geom (geom)
  );

  spd_fields #(.PAGE_ILV(PAGE_ILV), .FW(FW), .AW(AW)) u_fields (
    .geom         (geom),
    .mem_size     (mem_size),
    .addr_mask    (addr_mask),
    .row_start    (row_start),
    .col_mux      (col_mux),
    .bank_sel_pos (bank_sel_pos),
    .a10_pos      (a10_pos)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      cksum_err  <= 1'b0;
      width_warn <= 1'b0;
      cas_warn   <= 1'b0;
    end else begin
      done <= end_evt;
      if (end_evt) begin
        cksum_err  <= sum_bad;
        width_warn <= geom.width_bad;
        cas_warn   <= geom.cas_dflt;
      end
    end
  end

  assign rows        = geom.rows;
  assign cols        = geom.cols;
  assign chip_sel    = geom.chip_sel;
  assign bank_log2   = geom.bank_lg;
  assign cas_lat     = geom.cas;
  assign ld_to_pre   = geom.cas - 2'd1;
  assign refresh_cnt = geom.refresh;

  assert_done_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_vld && (in_idx == IDX_W'(SPD_LAST))));

  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(cksum_err) && $stable(width_warn) && $stable(cas_warn)));

  assert_clamped_geom_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rows <= 4'd14) && (cols <= 4'd11));

  assert_cas_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat >= 2'd2) && (ld_to_pre == cas_lat - 2'd1));

  assert_a10_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    a10_pos == col_mux + (PAGE_ILV ? FW'(0) : FW'(2)));

endmodule

// File: tb/test_spd_decoder.sv
module test_spd_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_vld = 1'b0;
  logic [7:0] in_idx = 8'd0;
  logic [7:0] in_data = 8'd0;

  always #4 clk = ~clk;

  // instance A: page interleave, optimistic CAS
  logic a_done, a_ce, a_ww, a_cw;
  logic [3:0] a_cs, a_rows, a_cols;
  logic [1:0] a_bl, a_cas, a_ldp;
  logic [7:0] a_ref, a_rs, a_cm, a_bs, a_a10;
  logic [31:0] a_size, a_mask;
  // instance B: bank interleave, pessimistic CAS
  logic b_done, b_ce, b_ww, b_cw;
  logic [3:0] b_cs, b_rows, b_cols;
  logic [1:0] b_bl, b_cas, b_ldp;
  logic [7:0] b_ref, b_rs, b_cm, b_bs, b_a10;
  logic [31:0] b_size, b_mask;

  spd_decoder i_spd_decoder (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_idx(in_idx), .in_data(in_data),
    .done(a_done), .cksum_err(a_ce), .width_warn(a_ww), .cas_warn(a_cw),
    .chip_sel(a_cs), .rows(a_rows), .cols(a_cols), .bank_log2(a_bl), .cas_lat(a_cas),
    .ld_to_pre(a_ldp), .refresh_cnt(a_ref), .mem_size(a_size), .addr_mask(a_mask),
    .row_start(a_rs), .col_mux(a_cm), .bank_sel_pos(a_bs), .a10_pos(a_a10));

  spd_decoder #(.PAGE_ILV(1'b0), .PESSIMISTIC(1'b1)) i_spd_decoder_alt (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_idx(in_idx), .in_data(in_data),
    .done(b_done), .cksum_err(b_ce), .width_warn(b_ww), .cas_warn(b_cw),
    .chip_sel(b_cs), .rows(b_rows), .cols(b_cols), .bank_log2(b_bl), .cas_lat(b_cas),
    .ld_to_pre(b_ldp), .refresh_cnt(b_ref), .mem_size(b_size), .addr_mask(b_mask),
    .row_start(b_rs), .col_mux(b_cm), .bank_sel_pos(b_bs), .a10_pos(b_a10));

  int vectors = 0;
  int fails = 0;

  // reference state
  int mem [64];
  int img [64];
  bit exp_done = 0;
  bit exp_ce = 0, exp_ww = 0, exp_cw_a = 0, exp_cw_b = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pick_cas(input int b, input bit pess);
    int lat = 3;
    if (pess) begin
      for (int k = 0; k < 3; k++) if (b[k]) lat = k + 1;
    end else begin
      for (int k = 2; k >= 0; k--) if (b[k]) lat = k + 1;
    end
    return (lat < 2) ? 2 : lat;
  endfunction

  task automatic check_outputs();
    int r, c, bl, rf, w, e, mx;
    longint sz;
    r = mem[3] % 16;  if (r > 14) r = 14;
    c = mem[4] % 16;  if (c > 11) c = 11;
    bl = (mem[17] == 2) ? 1 : (mem[17] == 4) ? 2 : (mem[17] == 8) ? 3 : 0;
    case (mem[12] % 128)
      1: rf = 2;  2: rf = 6;  3: rf = 29;  4: rf = 60;  5: rf = 120;
      default: rf = 14;
    endcase
    w  = mem[7] * 256 + mem[6];
    e  = r + c + bl + 3;
    sz = longint'(1) << e;
    mx = (r > c) ? r : c;
    // common to both variants
    chk("R11", "done A", a_done, exp_done);
    chk("R11", "done B", b_done, exp_done);
    chk("R6", "cksum_err A", a_ce, exp_ce);
    chk("R6", "cksum_err B", b_ce, exp_ce);
    chk("R5", "width_warn A", a_ww, exp_ww);
    chk("R5", "width_warn B", b_ww, exp_ww);
    chk("R4", "cas_warn A", a_cw, exp_cw_a);
    chk("R4", "cas_warn B", b_cw, exp_cw_b);
    chk("R1", "rows A", a_rows, r);
    chk("R1", "cols B", b_cols, c);
    chk("R1", "rows B", b_rows, r);
    chk("R1", "cols A", a_cols, c);
    chk("R1", "chip_sel", a_cs, mem[5] % 16);
    chk("R2", "bank_log2", b_bl, bl);
    chk("R3", "refresh_cnt", a_ref, rf);
    chk("R4", "cas_lat A", a_cas, pick_cas(mem[18], 0));
    chk("R4", "cas_lat B", b_cas, pick_cas(mem[18], 1));
    chk("R4", "ld_to_pre B", b_ldp, pick_cas(mem[18], 1) - 1);
    chk("R7", "mem_size", a_size, sz);
    chk("R7", "addr_mask", b_mask, (~(sz - 1)) & 64'hFFFF_FFFF);
    chk("R10", "bank_sel_pos", a_bs, (14 - mx) & 255);
    // page interleave variant
    chk("R8", "row_start A", a_rs, (32 - e) & 255);
    chk("R8", "col_mux A", a_cm, (c - 6) & 255);
    chk("R8", "a10 A", a_a10, (c - 6) & 255);
    // bank interleave variant
    chk("R9", "row_start B", b_rs, ((26 - (r + c + 3)) * 2) & 255);
    chk("R9", "col_mux B", b_cm, (c - 8) & 255);
    chk("R9", "a10 B", b_a10, (c - 6) & 255);
  endtask

  // one clock: drive at negedge, then compare at the next negedge
  task automatic step(input bit v, input int idx, input int d);
    in_vld  = v;
    in_idx  = 8'(idx);
    in_data = 8'(d);
    exp_done = 0;
    if (v && idx < 64) begin
      mem[idx] = d;
      if (idx == 63) begin
        int s = 0;
        int w2;
        for (int k = 0; k < 63; k++) s += mem[k];
        w2 = mem[7] * 256 + mem[6];
        exp_ce   = ((s % 256) != d);
        exp_ww   = !(w2 == 64 || w2 == 72);
        exp_cw_a = ((mem[18] % 8) == 0);
        exp_cw_b = exp_cw_a;
        exp_done = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check_outputs();
  endtask

  // send img, with idle gaps and high-index noise mixed in (R12)
  task automatic send_image(input bit good_sum, input bit noisy);
    int s = 0;
    for (int k = 0; k < 63; k++) s += img[k];
    img[63] = good_sum ? (s % 256) : ((s + 1) % 256);
    for (int k = 0; k < 64; k++) begin
      step(1, k, img[k]);
      if (noisy && (k % 9 == 4)) begin
        step(1, 64 + k, 8'hA5 ^ k);    // R12: ignored index
        step(0, k, 8'h3C);              // idle strobe
        step(1, 200 + (k % 50), 8'hFF); // R12: ignored index
      end
    end
    step(0, 0, 0);
  endtask

  task automatic base_image();
    for (int k = 0; k < 64; k++) img[k] = (k * 37 + 11) % 256;
  endtask

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R13: reset state
    chk("R13", "done", a_done, 0);
    chk("R13", "cksum_err", a_ce, 0);
    chk("R13", "cas_lat", a_cas, 3);
    chk("R13", "refresh_cnt", b_ref, 14);
    chk("R13", "rows", a_rows, 0);
    step(0, 0, 0);

    // typical module, good checksum, noisy stream
    base_image();
    img[3] = 8'h0C; img[4] = 8'h09; img[5] = 8'h01; img[6] = 64; img[7] = 0;
    img[12] = 8'h80; img[17] = 4; img[18] = 8'h06;
    send_image(1, 1);

    // clamping, width 72, latency 1 forced up, bad checksum
    base_image();
    img[3] = 8'hFF; img[4] = 8'h0C; img[5] = 8'h02; img[6] = 72; img[7] = 0;
    img[12] = 5; img[17] = 8; img[18] = 8'h01;
    send_image(0, 0);

    // no CAS bit, odd width, unknown refresh and bank codes
    base_image();
    img[3] = 9; img[4] = 8; img[5] = 1; img[6] = 32; img[7] = 0;
    img[12] = 9; img[17] = 3; img[18] = 8'h00;
    send_image(1, 1);

    // sweep remaining refresh codes and CAS patterns
    for (int t = 0; t < 4; t++) begin
      base_image();
      img[3] = 13 + (t % 2); img[4] = 10; img[5] = t; img[6] = 72; img[7] = t % 2;
      img[12] = 1 + t; img[17] = 2;
      img[18] = (t == 0) ? 2 : (t == 1) ? 4 : (t == 2) ? 3 : 7;
      send_image(t != 2, 0);
    end

    // R12: a full burst of ignored bytes after the last image
    for (int k = 64; k < 128; k++) step(1, k, k);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule